// File: doc/BRIEF.md
# DRAM Refresh Sequencer

This block generates the refresh traffic for an asynchronous DRAM array behind a CPU memory controller. A free-running interval counter raises a refresh request once per programmed period. The request is held pending until the memory bus is free. The sequencer then takes the row strobe, the column strobe and the address lines and runs one of three refresh methods:

- **Hidden:** the column strobe is held low and only the row strobe is pulsed.
- **Row-address-only:** the row strobe is pulsed while an internal row counter drives the address.
- **Column-before-row:** the column strobe falls one clock before the row strobe.

Each refresh cycle has a fixed length in CPU clocks: 12, 13 or 14. A burst option chains four cycles back to back, so a burst costs exactly four times one cycle.

The control is one state machine with three states:

- **ST_IDLE:** no refresh is running.
- **ST_WAIT:** a refresh is pending and a CPU cycle is still on the bus.
- **ST_RUN:** a refresh owns the strobes and the address.

Its transitions are:

- **IDLE→RUN:** a refresh is pending and the bus is free.
- **IDLE→WAIT:** a refresh is pending and the bus is busy.
- **WAIT→RUN:** the busy flag drops.
- **RUN→RUN:** the next cycle of a burst starts, and the phase count wraps.
- **RUN→IDLE:** the last clock of the last cycle.

The method and the burst flag are sampled when a refresh starts.

Top module: `dram_refresh_seq`

## Requirements
- R1: A refresh request is raised every `cfg_interval`+1 clocks. With the CPU idle, the first refresh starts (`ref_active` high) `cfg_interval`+2 clocks after reset is released. Later starts follow each other at `cfg_interval`+1 clock spacing whenever a refresh is shorter than that spacing.
- R2: Method code 0 (hidden) runs 12 clocks per cycle, numbered phases 0..11. `dram_cas_n` is low in every phase, and `dram_ras_n` is low in phases 1..7 only.
- R3: Method code 1 (row-address-only) runs 13 clocks per cycle. `dram_cas_n` stays high, `dram_ras_n` is low in phases 1..8, and `dram_addr` carries the row counter.
- R4: Method code 2 (column-before-row) runs 14 clocks per cycle. `dram_cas_n` is low in phases 1..9 and `dram_ras_n` is low in phases 2..9. Code 3 behaves exactly like code 2.
- R5: With `cfg_burst`=1, four cycles run back to back with no idle clock between them, so a burst lasts 48, 52 or 56 clocks. With `cfg_burst`=0, one cycle runs.
- R6: `ref_done` is high for exactly one clock: the last clock of a single refresh, or the last clock of the fourth cycle of a burst.
- R7: The row counter resets to 0 and steps by one, modulo 2^ROW_W, after each row-address-only cycle. Other methods leave it unchanged. `dram_addr` is 0 whenever the row is not being driven.
- R8: A pending refresh does not start while `cpu_busy` is high. It starts in the clock after `cpu_busy` is seen low.
- R9: `cpu_gnt` equals `cpu_req` only while the sequencer is idle with no refresh pending. It is 0 while a refresh is pending or running.
- R10: Changes to `cfg_method` or `cfg_burst` during a refresh have no effect on that refresh.
- R11: During reset and whenever no refresh runs, `dram_ras_n` and `dram_cas_n` are 1, `dram_addr` is 0 and `ref_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_interval | input | IV_W | Refresh period minus one, in clocks |
| cfg_method | input | 2 | Refresh method: 0 hidden, 1 row-address-only, 2 or 3 column-before-row |
| cfg_burst | input | 1 | 1: four cycles per refresh; 0: one cycle |
| cpu_req | input | 1 | CPU asks to start a memory cycle |
| cpu_busy | input | 1 | A CPU memory cycle is in progress |
| cpu_gnt | output | 1 | CPU may start its cycle |
| ref_active | output | 1 | Refresh owns the DRAM strobes and address |
| ref_done | output | 1 | Last clock of a refresh or burst |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_addr | output | ROW_W | Refresh row address |

## Verification
The request is registered once, and the start is registered once more. So the first `ref_active` is due `cfg_interval`+2 clocks after reset, and once `cpu_busy` drops the start is due one clock later. The bench counts falling edges from those points and compares at exactly that count.

Inside a refresh, every strobe and address value is a function of the phase, meaning the clocks since `ref_active` rose. The bench derives that function from the cycle length and checks it on every falling edge of the cycle. It also confirms that `ref_done` appears only at phase length−1 of the final cycle, and that the idle gap to the next start closes the period.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

    typedef enum logic [1:0] {
        RM_HIDDEN   = 2'd0,
        RM_RAS_ONLY = 2'd1,
        RM_CBR      = 2'd2,
        RM_CBR_ALT  = 2'd3
    } ref_method_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } ref_state_e;

    // Code 3 is an alias of column-before-row.
    function automatic ref_method_e norm_method(input logic [1:0] code);
        return (code == 2'd3) ? RM_CBR : ref_method_e'(code);
    endfunction

endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
    parameter int IV_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IV_W-1:0] interval,
    output logic            tick
);
    logic [IV_W-1:0] cnt_q;

    assign tick = (cnt_q >= interval);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/refresh_row_ctr.sv
module refresh_row_ctr #(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [ROW_W-1:0] row
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            row <= '0;
        else if (step)
            row <= row + 1'b1;
    end
endmodule

// File: rtl/refresh_strobes.sv
module refresh_strobes
    import refresh_pkg::*;
#(
    parameter int PH_W    = 4,
    parameter int CYC_HID = 12,
    parameter int CYC_RAS = 13,
    parameter int CYC_CBR = 14,
    parameter int PRECHG  = 4
) (
    input  logic            active,
    input  ref_method_e     method,
    input  logic [PH_W-1:0] phase,
    output logic            ras_n,
    output logic            cas_n,
    output logic            drive_row,
    output logic            cyc_last
);
    logic [PH_W-1:0] len_m1;
    logic [PH_W-1:0] ras_first;
    logic [PH_W-1:0] ras_last;
    logic            ras_on;
    logic            cas_on;

    always_comb begin
        unique case (method)
            RM_HIDDEN: begin
                len_m1    = PH_W'(CYC_HID - 1);
                ras_first = PH_W'(1);
            end
            RM_RAS_ONLY: begin
                len_m1    = PH_W'(CYC_RAS - 1);
                ras_first = PH_W'(1);
            end
            RM_CBR, RM_CBR_ALT: begin
                len_m1    = PH_W'(CYC_CBR - 1);
                ras_first = PH_W'(2);
            end
        endcase
    end

    assign ras_last = len_m1 - PH_W'(PRECHG);
    assign ras_on   = active && (phase >= ras_first) && (phase <= ras_last);

    always_comb begin
        unique case (method)
            RM_HIDDEN:          cas_on = active;
            RM_RAS_ONLY:        cas_on = 1'b0;
            RM_CBR, RM_CBR_ALT: cas_on = active && (phase >= PH_W'(1)) && (phase <= ras_last);
        endcase
    end

    assign ras_n     = !ras_on;
    assign cas_n     = !cas_on;
    assign drive_row = active && (method == RM_RAS_ONLY);
    assign cyc_last  = (phase == len_m1);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import refresh_pkg::*;
#(
    parameter int ROW_W     = 11,
    parameter int IV_W      = 16,
    parameter int CYC_HID   = 12,
    parameter int CYC_RAS   = 13,
    parameter int CYC_CBR   = 14,
    parameter int PRECHG    = 4,
    parameter int BURST_CNT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IV_W-1:0]  cfg_interval,
    input  logic [1:0]       cfg_method,
    input  logic             cfg_burst,
    input  logic             cpu_req,
    input  logic             cpu_busy,
    output logic             cpu_gnt,
    output logic             ref_active,
    output logic             ref_done,
    output logic             dram_ras_n,
    output logic             dram_cas_n,
    output logic [ROW_W-1:0] dram_addr
);
    localparam int CYC_MAX = (CYC_CBR > CYC_RAS)
                           ? ((CYC_CBR > CYC_HID) ? CYC_CBR : CYC_HID)
                           : ((CYC_RAS > CYC_HID) ? CYC_RAS : CYC_HID);
    localparam int PH_W  = $clog2(CYC_MAX);
    localparam int SUB_W = $clog2(BURST_CNT + 1);

    ref_state_e       state_q, state_d;
    logic [PH_W-1:0]  phase_q, phase_d;
    logic [SUB_W-1:0] sub_q, sub_d;
    ref_method_e      meth_q;
    logic             burst_q;
    logic             pend_q;

    logic             tick;
    logic             start;
    logic             cyc_last;
    logic             sub_last;
    logic             drive_row;
    logic             row_step;
    logic             run;
    logic [ROW_W-1:0] row;

    refresh_timer #(.IV_W(IV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .interval (cfg_interval),
        .tick     (tick)
    );

    refresh_row_ctr #(.ROW_W(ROW_W)) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (row_step),
        .row   (row)
    );

    refresh_strobes #(
        .PH_W    (PH_W),
        .CYC_HID (CYC_HID),
        .CYC_RAS (CYC_RAS),
        .CYC_CBR (CYC_CBR),
        .PRECHG  (PRECHG)
    ) u_strobes (
        .active    (run),
        .method    (meth_q),
        .phase     (phase_q),
        .ras_n     (dram_ras_n),
        .cas_n     (dram_cas_n),
        .drive_row (drive_row),
        .cyc_last  (cyc_last)
    );

    assign run      = (state_q == ST_RUN);
    assign sub_last = burst_q ? (sub_q == SUB_W'(BURST_CNT - 1)) : (sub_q == '0);
    assign start    = pend_q && !cpu_busy && (state_q != ST_RUN);
    assign row_step = run && cyc_last && (meth_q == RM_RAS_ONLY);

    // Next state, phase and cycle index
    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        sub_d   = sub_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pend_q)
                    state_d = cpu_busy ? ST_WAIT : ST_RUN;
            end
            ST_WAIT: begin
                if (!cpu_busy)
                    state_d = ST_RUN;
            end
            ST_RUN: begin
                if (cyc_last) begin
                    phase_d = '0;
                    sub_d   = sub_q + 1'b1;
                    if (sub_last)
                        state_d = ST_IDLE;
                end else begin
                    phase_d = phase_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (start) begin
            phase_d = '0;
            sub_d   = '0;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= '0;
            sub_q   <= '0;
            meth_q  <= RM_HIDDEN;
            burst_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            sub_q   <= sub_d;
            if (start) begin
                meth_q  <= norm_method(cfg_method);
                burst_q <= cfg_burst;
            end
            if (tick)
                pend_q <= 1'b1;
            else if (start)
                pend_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        ref_active = run;
        ref_done   = run && cyc_last && sub_last;
        cpu_gnt    = cpu_req && (state_q == ST_IDLE) && !pend_q;
        dram_addr  = drive_row ? row : '0;
    end
endmodule

// File: rtl/refresh_checker.sv
module refresh_checker #(
    parameter int ROW_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_busy,
    input logic             cpu_gnt,
    input logic             ref_active,
    input logic             ref_done,
    input logic             dram_ras_n,
    input logic             dram_cas_n,
    input logic [ROW_W-1:0] dram_addr
);
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_active |-> (dram_ras_n && dram_cas_n && (dram_addr == '0)));

    a_r6_done_inside: assert property (@(posedge clk) disable iff (!rst_n)
        ref_done |-> ref_active);

    a_r6_done_once: assert property (@(posedge clk) disable iff (!rst_n)
        ref_done |=> !ref_done);

    a_r8_start_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_active) |-> !$past(cpu_busy));

    a_r9_gnt_excl: assert property (@(posedge clk) disable iff (!rst_n)
        ref_active |-> !cpu_gnt);

    a_r5_ends_precharged: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_active) |-> $past(dram_ras_n));
endmodule

bind dram_refresh_seq refresh_checker #(.ROW_W(ROW_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_busy   (cpu_busy),
    .cpu_gnt    (cpu_gnt),
    .ref_active (ref_active),
    .ref_done   (ref_done),
    .dram_ras_n (dram_ras_n),
    .dram_cas_n (dram_cas_n),
    .dram_addr  (dram_addr)
);

// File: tb/tb_dram_refresh_seq.sv
module tb_dram_refresh_seq;
    localparam int ROW_W = 3;
    localparam int IV_W  = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n = 1'b0;
    logic [IV_W-1:0]  cfg_interval = '0;
    logic [1:0]       cfg_method = '0;
    logic             cfg_burst = 1'b0;
    logic             cpu_req = 1'b0;
    logic             cpu_busy = 1'b0;
    logic             cpu_gnt, ref_active, ref_done, dram_ras_n, dram_cas_n;
    logic [ROW_W-1:0] dram_addr;

    int nvec = 0;
    int nerr = 0;
    int row_m = 0;

    dram_refresh_seq #(.ROW_W(ROW_W), .IV_W(IV_W)) dut (
        .clk (clk), .rst_n (rst_n), .cfg_interval (cfg_interval),
        .cfg_method (cfg_method), .cfg_burst (cfg_burst),
        .cpu_req (cpu_req), .cpu_busy (cpu_busy), .cpu_gnt (cpu_gnt),
        .ref_active (ref_active), .ref_done (ref_done),
        .dram_ras_n (dram_ras_n), .dram_cas_n (dram_cas_n), .dram_addr (dram_addr)
    );

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int len_of(input int mm);
        return (mm == 0) ? 12 : (mm == 1) ? 13 : 14;
    endfunction

    function automatic int ras_exp(input int mm, input int p);
        int first = (mm == 2) ? 2 : 1;
        return (p >= first && p <= len_of(mm) - 5) ? 0 : 1;
    endfunction

    function automatic int cas_exp(input int mm, input int p);
        if (mm == 0) return 0;
        if (mm == 1) return 1;
        return (p >= 1 && p <= len_of(mm) - 5) ? 0 : 1;
    endfunction

    task automatic do_reset(input int m, input bit b, input int iv, input bit req, input bit busy);
        rst_n = 1'b0;
        cfg_method = 2'(m);
        cfg_burst = b;
        cfg_interval = IV_W'(iv);
        cpu_req = req;
        cpu_busy = busy;
        @(negedge clk);
        @(negedge clk);
        chk("R11 ras_n in reset", int'(dram_ras_n), 1);
        chk("R11 cas_n in reset", int'(dram_cas_n), 1);
        chk("R11 addr in reset", int'(dram_addr), 0);
        chk("R11 active in reset", int'(ref_active), 0);
        chk("R11 done in reset", int'(ref_done), 0);
        rst_n = 1'b1;
        row_m = 0;
    endtask

    task automatic wait_start(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ref_active && n < 1000);
    endtask

    // Called on the falling edge where ref_active was first seen high (phase 0).
    task automatic run_check(input int m, input bit b, input bit flip);
        int mm = (m == 3) ? 2 : m;
        int L = len_of(mm);
        int nsub = b ? 4 : 1;
        string tag = flip ? "R10" : (mm == 0) ? "R2" : (mm == 1) ? "R3" : "R4";
        for (int s = 0; s < nsub; s++) begin
            for (int p = 0; p < L; p++) begin
                if (flip && s == 0 && p == 3) begin
                    cfg_method = 2'((mm + 1) % 3);
                    cfg_burst = !b;
                end
                chk({tag, " R5 active"}, int'(ref_active), 1);
                chk({tag, " ras_n"}, int'(dram_ras_n), ras_exp(mm, p));
                chk({tag, " cas_n"}, int'(dram_cas_n), cas_exp(mm, p));
                chk({tag, " R7 addr"}, int'(dram_addr),
                    (mm == 1) ? ((row_m + s) % (1 << ROW_W)) : 0);
                chk({tag, " R6 done"}, int'(ref_done), (s == nsub - 1 && p == L - 1) ? 1 : 0);
                chk({tag, " R9 gnt"}, int'(cpu_gnt), 0);
                @(negedge clk);
            end
        end
        chk({tag, " R5 end"}, int'(ref_active), 0);
        chk({tag, " R11 idle ras_n"}, int'(dram_ras_n), 1);
        if (mm == 1) row_m = (row_m + nsub) % (1 << ROW_W);
        if (flip) begin
            cfg_method = 2'(m);
            cfg_burst = b;
        end
    endtask

    task automatic run_all();
        int n;
        int iv;
        // R1..R5, R10: sweep over all method codes and burst settings
        for (int m = 0; m < 4; m++) begin
            for (int b = 0; b < 2; b++) begin
                int tot;
                iv = 70;
                tot = len_of((m == 3) ? 2 : m) * ((b != 0) ? 4 : 1);
                do_reset(m, b[0], iv, 1'b0, 1'b0);
                wait_start(n);
                chk("R1 first start", n, iv + 2);
                run_check(m, b[0], 1'b0);
                wait_start(n);
                chk("R1 period", tot + n, iv + 1);
                run_check(m, b[0], 1'b1);
                wait_start(n);
                chk("R1 period after R10", tot + n, iv + 1);
                run_check(m, b[0], 1'b0);
            end
        end

        // R7: only row-address-only cycles step the row counter
        do_reset(0, 1'b0, 40, 1'b0, 1'b0);
        wait_start(n);
        run_check(0, 1'b0, 1'b0);
        cfg_method = 2'd1;
        wait_start(n);
        run_check(1, 1'b0, 1'b0);
        cfg_method = 2'd2;
        wait_start(n);
        run_check(2, 1'b0, 1'b0);
        cfg_method = 2'd1;
        wait_start(n);
        chk("R7 row after step", int'(dram_addr), 1);
        run_check(1, 1'b0, 1'b0);

        // R8, R9: arbitration against a busy CPU
        iv = 40;
        do_reset(2, 1'b0, iv, 1'b1, 1'b1);
        for (int k = 1; k <= iv; k++) begin
            @(negedge clk);
            chk("R9 gnt before request", int'(cpu_gnt), 1);
        end
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            chk("R9 gnt while pending", int'(cpu_gnt), 0);
            chk("R8 held while busy", int'(ref_active), 0);
        end
        cpu_busy = 1'b0;
        @(negedge clk);
        chk("R8 start after busy", int'(ref_active), 1);
        run_check(2, 1'b0, 1'b0);
        chk("R9 gnt back after refresh", int'(cpu_gnt), 1);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                nerr++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule